// File: doc/BRIEF.md
# Stop-Mode Wake-Up Warm-Up Controller

This block puts a small controller into a low-power halt and brings it back safely. A stop request closes the system clock gate and turns the oscillator off. Bus read and write strobes are held inactive, and the external pins are either driven or released according to a drive-enable setting. An enabled, pending interrupt ends the halt. The oscillator is switched back on and a warm-up counter runs before the clock gate may open again.

The warm-up length is chosen by a 2-bit code as a power-of-two number of source cycles. The count advances only on ticks of the clock source that a select bit picks for use after wake-up, either fast or slow. The select bit and the length code are both captured when the halt begins. The analog oscillator and the glitch-free clock multiplexer are outside the block. The block drives their enable and select signals. Each source clock is represented as a one-cycle tick on the reference clock.

Top module: `stop_warmup_ctrl`

## Requirements
- R1: Out of reset the block is running: sysClkEn=1, oscOff=0, busHold=0, pinDrive=1, clkSelSlow=0.
- R2: A stop request sampled while running with no pending interrupt gives, one cycle later, sysClkEn=0, oscOff=1 and busHold=1, and the halt persists while no interrupt is pending.
- R3: A stop request sampled while irqPending is high is ignored: the block stays running (sysClkEn=1, oscOff=0).
- R4: While the clock gate is closed, pinDrive equals driveEn. While running, pinDrive is 1.
- R5: An interrupt sampled during the halt gives, one cycle later, oscOff=0 with sysClkEn still 0 (warm-up).
- R6: Warm-up lasts exactly 2^LOG_A selected ticks for wuSel=01, 2^LOG_B for 10, 2^LOG_C for 11. Code 00 behaves as 2^LOG_C. The gate reopens at the edge that samples the last tick.
- R7: Only ticks of the chosen source advance the warm-up: slowTick when clkSelSlow=1, fastTick when clkSelSlow=0. The other source's ticks have no effect.
- R8: slowSel and wuSel are captured at stop entry. Changes to them while the gate is closed alter neither clkSelSlow nor the warm-up length.
- R9: An interrupt arriving during warm-up does not restart or lengthen the count.
- R10: busHold is 1 exactly while sysClkEn is 0. After warm-up both return to the running values.
- R11: While running, clkSelSlow follows slowSel with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stopReq | input | 1 | Request to enter the halt |
| irqPending | input | 1 | An enabled interrupt is pending |
| driveEn | input | 1 | Pin drive setting applied while halted |
| slowSel | input | 1 | Clock source for after wake-up: 1 slow, 0 fast |
| wuSel | input | 2 | Warm-up length code |
| fastTick | input | 1 | One-cycle pulse per fast source cycle |
| slowTick | input | 1 | One-cycle pulse per slow source cycle |
| sysClkEn | output | 1 | System clock gate enable |
| oscOff | output | 1 | Oscillator disable |
| clkSelSlow | output | 1 | Clock mux select: 1 slow, 0 fast |
| busHold | output | 1 | Holds read/write strobes inactive |
| pinDrive | output | 1 | 1 drives external pins, 0 releases them |

## Verification
A wrong state or counter value shows up as a gate that reopens early or late. The bench counts that error to the exact tick, because it supplies every selected tick itself and knows the expected power-of-two total. A wrong captured select shows on clkSelSlow in the first cycle of warm-up. A wrong length code shows at the end of warm-up as a tick count that does not match. A stale state shows one cycle after a request or interrupt, on oscOff and sysClkEn. The sweep covers every length code, both sources, both drive settings and two tick densities. Half the runs also change the settings mid-halt.

// File: rtl/swu_pkg.sv
package swu_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WARM = 2'd2
  } swuState_e;

  // strobes from control to the warm-up datapath
  typedef struct packed {
    logic latchCfg;  // capture source select and length code
    logic cntClear;  // hold the warm-up counter at zero
    logic cntRun;    // counter may advance on the chosen tick
  } swuStrobe_t;
endpackage

// File: rtl/swu_ctrl.sv
module swu_ctrl
  import swu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       irqPending,
  input  logic       driveEn,
  input  logic       cntDone,
  output swuStrobe_t strobe,
  output logic       sysClkEn,
  output logic       oscOff,
  output logic       busHold,
  output logic       pinDrive
);
  swuState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN:  if (stopReq && !irqPending) stateNxt = ST_STOP;
      ST_STOP: if (irqPending)             stateNxt = ST_WARM;
      ST_WARM: if (cntDone)                stateNxt = ST_RUN;
      default:                             stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe.latchCfg = (state == ST_RUN);
    strobe.cntClear = (state != ST_WARM);
    strobe.cntRun   = (state == ST_WARM);
  end

  assign sysClkEn = (state == ST_RUN);
  assign oscOff   = (state == ST_STOP);
  assign busHold  = (state != ST_RUN);
  assign pinDrive = (state == ST_RUN) ? 1'b1 : driveEn;
endmodule

// File: rtl/swu_warmup_dp.sv
module swu_warmup_dp
  import swu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LOG_A = 8,
  parameter int LOG_B = 14,
  parameter int LOG_C = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  swuStrobe_t strobe,
  input  logic       slowSel,
  input  logic [1:0] wuSel,
  input  logic       fastTick,
  input  logic       slowTick,
  output logic       clkSelSlow,
  output logic       cntDone
);
  localparam logic [CNT_W-1:0] ONES   = '1;
  localparam logic [CNT_W-1:0] LAST_A = ONES >> (CNT_W - LOG_A);
  localparam logic [CNT_W-1:0] LAST_B = ONES >> (CNT_W - LOG_B);
  localparam logic [CNT_W-1:0] LAST_C = ONES >> (CNT_W - LOG_C);

  logic             selSlowQ;
  logic [1:0]       wuSelQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic             tickSel;
  logic             atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSlowQ <= 1'b0;
      wuSelQ   <= 2'b00;
    end else if (strobe.latchCfg) begin
      selSlowQ <= slowSel;
      wuSelQ   <= wuSel;
    end
  end

  always_comb begin
    unique case (wuSelQ)
      2'b01:   lastCnt = LAST_A;
      2'b10:   lastCnt = LAST_B;
      default: lastCnt = LAST_C;  // 11, and reserved 00
    endcase
  end

  assign tickSel = selSlowQ ? slowTick : fastTick;
  assign atLast  = (cnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   cnt <= '0;
    else if (strobe.cntClear)                    cnt <= '0;
    else if (strobe.cntRun && tickSel && !atLast) cnt <= cnt + 1'b1;
  end

  assign cntDone    = strobe.cntRun && tickSel && atLast;
  assign clkSelSlow = selSlowQ;
endmodule

// File: rtl/stop_warmup_ctrl.sv
module stop_warmup_ctrl
  import swu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LOG_A = 8,
  parameter int LOG_B = 14,
  parameter int LOG_C = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       irqPending,
  input  logic       driveEn,
  input  logic       slowSel,
  input  logic [1:0] wuSel,
  input  logic       fastTick,
  input  logic       slowTick,
  output logic       sysClkEn,
  output logic       oscOff,
  output logic       clkSelSlow,
  output logic       busHold,
  output logic       pinDrive
);
  swuStrobe_t strobe;
  logic       cntDone;

  swu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stopReq    (stopReq),
    .irqPending (irqPending),
    .driveEn    (driveEn),
    .cntDone    (cntDone),
    .strobe     (strobe),
    .sysClkEn   (sysClkEn),
    .oscOff     (oscOff),
    .busHold    (busHold),
    .pinDrive   (pinDrive)
  );

  swu_warmup_dp #(
    .CNT_W (CNT_W),
    .LOG_A (LOG_A),
    .LOG_B (LOG_B),
    .LOG_C (LOG_C)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .slowSel    (slowSel),
    .wuSel      (wuSel),
    .fastTick   (fastTick),
    .slowTick   (slowTick),
    .clkSelSlow (clkSelSlow),
    .cntDone    (cntDone)
  );
endmodule

// File: rtl/swu_chk.sv
module swu_chk (
  input logic       clk,
  input logic       rstN,
  input logic       stopReq,
  input logic       irqPending,
  input logic       driveEn,
  input logic       slowSel,
  input logic [1:0] wuSel,
  input logic       fastTick,
  input logic       slowTick,
  input logic       sysClkEn,
  input logic       oscOff,
  input logic       clkSelSlow,
  input logic       busHold,
  input logic       pinDrive
);
  p_stop_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sysClkEn && stopReq && !irqPending) |=> (oscOff && !sysClkEn));

  p_stop_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (oscOff && !irqPending) |=> oscOff);

  p_no_stop_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sysClkEn && irqPending) |=> (sysClkEn && !oscOff));

  p_pin_halt_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sysClkEn |-> (pinDrive == driveEn));

  p_pin_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    sysClkEn |-> pinDrive);

  p_wake_r5: assert property (@(posedge clk) disable iff (!rstN)
    (oscOff && irqPending) |=> (!oscOff && !sysClkEn));

  p_tick_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysClkEn) |-> $past(clkSelSlow ? slowTick : fastTick));

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sysClkEn |=> $stable(clkSelSlow));

  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busHold == !sysClkEn);
endmodule

bind stop_warmup_ctrl swu_chk u_chk (.*);

// File: tb/sim_stop_warmup_ctrl.sv
`timescale 1ns/1ps
module sim_stop_warmup_ctrl;
  localparam int CW = 4;
  localparam int LA = 2;
  localparam int LB = 3;
  localparam int LC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0, irqPending = 1'b0, driveEn = 1'b0, slowSel = 1'b0;
  logic [1:0] wuSel = 2'b00;
  logic fastTick = 1'b0, slowTick = 1'b0;
  logic sysClkEn, oscOff, clkSelSlow, busHold, pinDrive;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  stop_warmup_ctrl #(.CNT_W(CW), .LOG_A(LA), .LOG_B(LB), .LOG_C(LC)) u0 (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .irqPending(irqPending),
    .driveEn(driveEn), .slowSel(slowSel), .wuSel(wuSel),
    .fastTick(fastTick), .slowTick(slowTick), .sysClkEn(sysClkEn),
    .oscOff(oscOff), .clkSelSlow(clkSelSlow), .busHold(busHold),
    .pinDrive(pinDrive));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expLen(input logic [1:0] code);
    case (code)
      2'b01:   return 1 << LA;
      2'b10:   return 1 << LB;
      default: return 1 << LC;
    endcase
  endfunction

  task automatic runSeq(input logic [1:0] w, input logic s, input logic d,
                        input int dense, input logic disturb);
    int nTicks = 0;
    int k = 0;
    slowSel = s; wuSel = w; driveEn = d; stopReq = 1'b0; irqPending = 1'b0;
    fastTick = 1'b0; slowTick = 1'b0;
    @(negedge clk);
    chk("R11 clkSelSlow follows slowSel", clkSelSlow, s);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R2 gate closed", sysClkEn, 0);
    chk("R2 osc off", oscOff, 1);
    chk("R10 bus held", busHold, 1);
    chk("R4 pin drive halted", pinDrive, d);
    if (disturb) begin slowSel = ~s; wuSel = ~w; end
    repeat (2) @(negedge clk);
    chk("R2 halt persists", oscOff, 1);
    irqPending = 1'b1;
    @(negedge clk);
    irqPending = 1'b0;
    chk("R5 osc on", oscOff, 0);
    chk("R5 gate still closed", sysClkEn, 0);
    chk("R8 captured select", clkSelSlow, s);
    while (!sysClkEn && k < 400) begin
      logic t;
      t = (dense != 0) ? 1'b1 : ((k % 3) == 1);
      if (s) begin slowTick = t; fastTick = 1'b1; end
      else   begin fastTick = t; slowTick = 1'b1; end
      irqPending = disturb && ((k % 5) == 2);  // R9 stimulus
      if (t) nTicks++;
      k++;
      @(negedge clk);
    end
    irqPending = 1'b0; fastTick = 1'b0; slowTick = 1'b0;
    chk("R6 R7 R9 warm-up tick count", nTicks, expLen(w));
    chk("R10 bus released", busHold, 0);
    chk("R4 pin drive running", pinDrive, 1);
    chk("R10 osc on after wake", oscOff, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 sysClkEn", sysClkEn, 1);
    chk("R1 oscOff", oscOff, 0);
    chk("R1 busHold", busHold, 0);
    chk("R1 pinDrive", pinDrive, 1);
    chk("R1 clkSelSlow", clkSelSlow, 0);

    stopReq = 1'b1; irqPending = 1'b1;
    @(negedge clk);
    stopReq = 1'b0; irqPending = 1'b0;
    chk("R3 request ignored gate", sysClkEn, 1);
    chk("R3 request ignored osc", oscOff, 0);
    @(negedge clk);
    chk("R3 still running", sysClkEn, 1);

    slowSel = 1'b1;
    @(negedge clk);
    chk("R11 follows to 1", clkSelSlow, 1);
    slowSel = 1'b0;
    @(negedge clk);
    chk("R11 follows to 0", clkSelSlow, 0);

    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 2; s++)
        for (int d = 0; d < 2; d++)
          for (int dn = 0; dn < 2; dn++)
            runSeq(w[1:0], s[0], d[0], dn, logic'(dn == d));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule